// File: doc/BRIEF.md
# I2C Page-Write Slave Controller

This block is the I2C slave front end of a small nonvolatile byte array. It watches the open-drain SCL and SDA lines, recognises start and stop conditions, and decodes a write transfer: a device address byte, an upper address byte, a lower address byte, then data bytes. The data bytes collect in an eight-entry page buffer. Every accepted byte is acknowledged by pulling SDA low during the ninth clock.

A stop that arrives cleanly after at least one complete, acknowledged data byte starts a modelled write cycle. The buffered bytes are copied to the array port one per clock, and the slave then stays busy for a parameterised number of clocks. While busy it acknowledges nothing, so a master can poll the device address until it is acknowledged. A stop that arrives too early, or part way through a byte, drops the transfer and leaves the array alone. A repeated start does the same.

Top module: `i2c_page_wr_slave`

## Requirements
- R1: After reset, sda_oe_o is 0 and no array write occurs until a transfer is committed.
- R2: In the first byte after a start, bits 7..1 are compared with DEV_ADDR and bit 0 is the read/write flag (0 = write). On a match the slave ACKs by asserting sda_oe_o through the ninth SCL pulse. On a mismatch it does not ACK and ignores the bus until the next start.
- R3: The upper address byte must be 0x00. Any other value is not ACKed, and the transfer is dropped.
- R4: The lower address byte and every data byte are ACKed. Each accepted data byte moves the buffer position on by one.
- R5: Positions wrap inside an 8-byte page. The page base is the lower address with bits 2..0 cleared, and the position after offset 7 is offset 0 of the same page.
- R6: When more than 8 data bytes are sent, later bytes replace earlier ones at the same offset, and the array receives the last value for each offset.
- R7: A stop after at least one complete data byte and its ACK commits the page. mem_we_o pulses once per loaded offset, in ascending address order within the page, and offsets never loaded are not written.
- R8: A stop before the first complete data byte plus ACK, or after two or more bits of a later byte, commits nothing and leaves the slave ready to ACK at once.
- R9: For WR_CYCLES clocks from the start of a commit, the slave ACKs nothing, including its own address.
- R10: Once the write cycle has ended, a matching address byte with either read/write value is ACKed again.
- R11: A repeated start during a write transfer discards the buffered bytes without writing the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 8 | Array byte address |
| mem_data_o | output | 8 | Array write data |

## Verification
The bench writes pages that start mid-page, wrap past offset 7, and run past eight bytes. A design that carried into the next page, or wrote a byte once per arrival rather than once per offset, would leave a wrong byte in the array model. It stops transfers with no data, part way through a byte, and by repeated start. A design that committed anyway would bump the write count, and one that stayed busy would refuse the next address. Polling right after a commit must be refused at least once and then ACKed. An early ACK or a slave that never recovers both show up in the poll results.

// File: rtl/i2c_pw_pkg.sv
package i2c_pw_pkg;
  localparam int ADDR_W = 8;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_DATA} phase_e;
endpackage

// File: rtl/i2c_pw_bus_sync.sv
module i2c_pw_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges with SCL held high on both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_pw_page_buf.sv
module i2c_pw_page_buf #(
  parameter int PAGE_BYTES = 8,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_vld_o
);
  logic [7:0] data_q [PAGE_BYTES];
  logic       vld_q  [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_i && wr_idx_i == PW'(g)) begin
        data_q[g] <= wr_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
endmodule

// File: rtl/i2c_pw_commit.sv
module i2c_pw_commit #(
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 1250000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(WR_CYCLES + 1),
  localparam int AW = i2c_pw_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  input  logic [7:0]    rd_data_i,
  input  logic          rd_vld_i,
  output logic [PW-1:0] rd_idx_o,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  logic          sweep_q;
  logic [PW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
    end else if (go_i) begin
      sweep_q <= 1'b1;
      idx_q   <= '0;
      cnt_q   <= CW'(WR_CYCLES);
      base_q  <= base_i;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (sweep_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == PW'(PAGE_BYTES - 1)) sweep_q <= 1'b0;
      end
    end
  end

  // sweep finishes well inside the busy window (WR_CYCLES > PAGE_BYTES)
  assign rd_idx_o = idx_q;
  assign busy_o   = cnt_q != '0;
  assign we_o     = sweep_q & rd_vld_i;
  assign addr_o   = base_q | AW'(idx_q);
  assign data_o   = rd_data_i;
endmodule

// File: rtl/i2c_page_wr_slave.sv
module i2c_page_wr_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h6F,
  parameter int         PAGE_BYTES = 8,
  parameter int         WR_CYCLES  = 1250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       mem_we_o,
  output logic [7:0] mem_addr_o,
  output logic [7:0] mem_data_o
);
  import i2c_pw_pkg::*;
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'(PAGE_BYTES - 1);

  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic busy, commit_go_q;
  phase_e phase_q, nxt_q, byte_nxt;
  logic [3:0] bit_cnt_q;
  logic in_ack_q, ack_q, have_q, byte_ack;
  logic [7:0] shreg_q;
  logic [PW-1:0] ptr_q, rd_idx;
  logic [ADDR_W-1:0] base_q;
  logic buf_wr, buf_clr, rd_vld;
  logic [7:0] rd_data;

  i2c_pw_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
  );

  always_comb begin
    byte_ack = 1'b0;
    byte_nxt = PH_IDLE;
    unique case (phase_q)
      PH_DEV:  begin
        byte_ack = shreg_q[7:1] == DEV_ADDR;
        byte_nxt = shreg_q[0] ? PH_IDLE : PH_AHI;  // read: ACK only
      end
      PH_AHI:  begin byte_ack = shreg_q == 8'h00; byte_nxt = PH_ALO;  end
      PH_ALO:  begin byte_ack = 1'b1;             byte_nxt = PH_DATA; end
      PH_DATA: begin byte_ack = 1'b1;             byte_nxt = PH_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      nxt_q       <= PH_IDLE;
      bit_cnt_q   <= '0;
      in_ack_q    <= 1'b0;
      ack_q       <= 1'b0;
      have_q      <= 1'b0;
      shreg_q     <= '0;
      ptr_q       <= '0;
      base_q      <= '0;
      commit_go_q <= 1'b0;
    end else begin
      commit_go_q <= 1'b0;
      if (busy || start_det || stop_det) begin
        // stop rides on one SCL rise, so up to one shifted bit is tolerated
        if (!busy && stop_det && phase_q == PH_DATA && have_q && !in_ack_q
            && bit_cnt_q <= 4'd1)
          commit_go_q <= 1'b1;
        phase_q   <= (!busy && start_det) ? PH_DEV : PH_IDLE;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        ack_q     <= 1'b0;
        have_q    <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise && !in_ack_q) begin
          shreg_q   <= {shreg_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
        if (scl_fall) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            ack_q    <= 1'b0;
            phase_q  <= ack_q ? nxt_q : PH_IDLE;
            if (phase_q == PH_DATA) begin
              ptr_q  <= ptr_q + 1'b1;
              have_q <= 1'b1;
            end
          end else if (bit_cnt_q == 4'd8) begin
            bit_cnt_q <= '0;
            in_ack_q  <= 1'b1;
            ack_q     <= byte_ack;
            nxt_q     <= byte_nxt;
            if (phase_q == PH_ALO) begin
              ptr_q  <= shreg_q[PW-1:0];
              base_q <= shreg_q & ~PG_MASK;
            end
          end
        end
      end
    end
  end

  assign buf_clr = start_det & ~busy;
  assign buf_wr  = scl_fall & in_ack_q & ack_q & (phase_q == PH_DATA)
                 & ~busy & ~start_det & ~stop_det;

  i2c_pw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(buf_clr), .wr_i(buf_wr), .wr_idx_i(ptr_q), .wr_data_i(shreg_q),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_vld_o(rd_vld)
  );

  i2c_pw_commit #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk_i, .rst_ni,
    .go_i(commit_go_q), .base_i(base_q),
    .rd_data_i(rd_data), .rd_vld_i(rd_vld), .rd_idx_o(rd_idx),
    .busy_o(busy), .we_o(mem_we_o), .addr_o(mem_addr_o), .data_o(mem_data_o)
  );

  assign sda_oe_o = ack_q;
endmodule

// File: rtl/i2c_pw_checker.sv
module i2c_pw_checker #(
  parameter int PAGE_BYTES = 8,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_i,
  input logic       mem_we_i,
  input logic [7:0] mem_addr_i,
  input logic       busy_i,
  input logic       go_i
);
  // R9: no ACK while the write cycle runs
  a_r9_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  // R7: array writes only inside a commit
  a_r7_we_in_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> busy_i);

  // R7: back-to-back writes climb within one page
  a_r7_ascend_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && $past(mem_we_i)) |->
      (mem_addr_i[7:PW] == $past(mem_addr_i[7:PW])) && (mem_addr_i > $past(mem_addr_i)));

  // R7: a commit request always opens a busy window
  a_r7_go_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> busy_i);

  // R8: busy never starts without a commit request
  a_r8_no_spurious_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !go_i) |=> !busy_i);
endmodule

bind i2c_page_wr_slave i2c_pw_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .mem_we_i(mem_we_o),
  .mem_addr_i(mem_addr_o), .busy_i(busy), .go_i(commit_go_q)
);

// File: tb/i2c_page_wr_slave_tb.sv
module i2c_page_wr_slave_tb;
  localparam logic [6:0] DEV = 7'h6F;
  localparam int WRC = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we;
  logic [7:0] mem_addr, mem_data;
  logic sda_line;
  int total = 0, bad = 0, wr_cnt = 0;
  logic [7:0] dut_mem [256];
  logic [7:0] exp_mem [256];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_page_wr_slave #(.DEV_ADDR(DEV), .PAGE_BYTES(8), .WR_CYCLES(WRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always @(posedge clk) if (mem_we) begin
    dut_mem[mem_addr] <= mem_data;
    wr_cnt <= wr_cnt + 1;
  end

  // addr, count, first data
  localparam logic [23:0] VECS [6] = '{
    {8'h10, 8'd1,  8'hA0},
    {8'h23, 8'd3,  8'h51},
    {8'h2E, 8'd4,  8'h70},
    {8'h40, 8'd8,  8'h11},
    {8'h55, 8'd11, 8'h80},
    {8'hF8, 8'd2,  8'hC3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10); scl_m = 1'b0; tick(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0; tick(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5);
    acked = !sda_line;
    tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic poll(output int tries, output bit first_ack);
    bit a;
    tries = 0;
    first_ack = 1'b0;
    do begin
      bus_start();
      send_byte({DEV, 1'b1}, a);
      bus_stop();
      if (tries == 0) first_ack = a;
      tries++;
    end while (!a && tries < 100);
  endtask

  function automatic int mem_mismatch();
    int n = 0;
    for (int i = 0; i < 256; i++) if (dut_mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    int tries, w0;
    bit fa;
    for (int i = 0; i < 256; i++) begin dut_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    tick(5);
    rst_n = 1'b1;
    tick(20);
    check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    check(wr_cnt == 0, "R1 no writes after reset", wr_cnt, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] la, n, d0, base;
      bit all_ack;
      la = VECS[v][23:16]; n = VECS[v][15:8]; d0 = VECS[v][7:0];
      base = la & 8'hF8;
      all_ack = 1'b1;
      w0 = wr_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      check(a, "R2 device address ACK", a, 1);
      send_byte(8'h00, a);
      check(a, "R3 zero upper address ACK", a, 1);
      send_byte(la, a); all_ack &= a;
      for (int k = 0; k < n; k++) begin
        send_byte(d0 + 8'(k), a);
        all_ack &= a;
        exp_mem[base | ((la + 8'(k)) & 8'h07)] = d0 + 8'(k);  // R5 wrap, R6 overwrite
      end
      check(all_ack, "R4 address and data ACK", all_ack, 1);
      bus_stop();
      poll(tries, fa);
      check(!fa, "R9 no ACK right after commit", fa, 0);
      check(tries > 1 && tries < 100, "R10 ACK after write cycle", tries, 2);
      check(wr_cnt - w0 == ((n > 8) ? 8 : int'(n)), "R7 one write per loaded offset",
            wr_cnt - w0, (n > 8) ? 8 : int'(n));
      check(mem_mismatch() == 0, "R5 R6 R7 array contents", mem_mismatch(), 0);
    end

    // R2: wrong device address, later bytes ignored
    w0 = wr_cnt;
    bus_start();
    send_byte({7'h12, 1'b0}, a);
    check(!a, "R2 mismatch not ACKed", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 ignored until next start", a, 0);
    bus_stop();

    // R3: upper address nonzero
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h01, a);
    check(!a, "R3 nonzero upper address NACK", a, 0);
    send_byte(8'h33, a);
    check(!a, "R3 transfer dropped", a, 0);
    bus_stop();

    // R8: stop before any data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h68, a);
    bus_stop();
    poll(tries, fa);
    check(fa, "R8 not busy after early stop", fa, 1);

    // R8: stop mid-byte after one full data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h70, a);
    send_byte(8'hEE, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    poll(tries, fa);
    check(fa, "R8 not busy after mid-byte stop", fa, 1);

    // R11: repeated start discards buffer
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h80, a);
    send_byte(8'h5A, a);
    send_byte(8'hA5, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    check(a, "R11 address ACKed after repeated start", a, 1);
    bus_stop();
    tick(50);
    check(wr_cnt == w0, "R8 R11 no array writes from dropped transfers", wr_cnt - w0, 0);
    check(mem_mismatch() == 0, "R8 R11 array untouched", mem_mismatch(), 0);
    check(sda_oe == 1'b0, "R1 bus released at end", sda_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule